// File: doc/BRIEF.md
# Processor start and halt sequencer

This block decides what a small processor does when it comes out of reset, and what happens when it leaves or returns to console mode. A two-bit power-up mode selector and a level-sensitive halt request are sampled together after reset. Depending on the pair, the block does one of these things: fetches a start address from a fixed low-memory word, jumps to a fixed boot address, fetches a trap vector (PC and PS), or hands control to user microcode. It may instead print a six-digit octal value on the console and wait there.

From console mode, a start command loads the PC with the value entered, clears the PS, and pulses a bus initialize line for a timed interval. The block then waits a second timed interval and enters a service check. At the service check, a halt request that is still asserted sends the processor straight back to the console. While the program runs, the halt request is honoured only at instruction boundaries.

Every request the block makes uses a valid/ready handshake, and the sequencer stalls until each one is taken. The three kinds of request are a memory read, a PC/PS load and a console character. Both timed intervals are counted in clock cycles derived from the clock-period parameter.

Top module: `start_seq`

## Requirements
- R1: Mode 0 with halt negated reads memory word 000024 (octal), loads the PC with the returned data without loading the PS (`ld_ps_en` = 0), and then runs.
- R2: Mode 0 with halt asserted reads word 000024 and prints the returned data, then enters console mode.
- R3: Mode 1 prints the value on `cur_pc` (sampled in the first cycle after reset) and enters console mode, whatever the halt level.
- R4: Mode 2 with halt negated loads the PC with 173000 (octal), leaves the PS unloaded, and runs. Mode 2 with halt asserted prints 173000 and enters console mode.
- R5: Mode 3 without user microcode prints nothing. It reads word 000010 and then word 000012, then loads the PC from the first and the PS from the second (`ld_ps_en` = 1), and runs. With user microcode present, it raises `ucode_go` for one cycle, issues no request, and runs.
- R6: Every printout is nine characters. The first six are octal digits, most significant first, each sent as ASCII 0x30 plus the digit value. They are followed by 0x0D, 0x0A and 0x40.
- R7: In console mode, a `start_cmd` loads the PC with `start_val` when `start_has_val` is 1 and with 0 otherwise, and loads the PS with 0 (`ld_ps_en` = 1). Outside console mode, `start_cmd` has no effect.
- R8: After a start load is accepted, `bus_init` is high for exactly ceil(INIT_NS*1000/CLK_PS) cycles. It is then low for ceil(WAIT_NS*1000/CLK_PS) cycles before the service check.
- R9: At the service check after a start, an asserted halt prints `cur_pc` and enters console mode. A negated halt starts the run.
- R10: While running, halt is acted on only in a cycle where `instr_bnd` is high. The block then prints `cur_pc` and enters console mode.
- R11: A request whose ready is low keeps its valid high and its address or data unchanged into the next cycle.
- R12: During reset no request is valid, and `running`, `in_console`, `bus_init` and `ucode_go` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Power-up mode select |
| halt_req | input | 1 | Level-sensitive halt request |
| ucode_present | input | 1 | User microcode is available (mode 3) |
| instr_bnd | input | 1 | Processor is at an instruction boundary |
| cur_pc | input | DW | Current program counter, for printing |
| start_cmd | input | 1 | Start command pulse from the console parser |
| start_has_val | input | 1 | A start address was entered |
| start_val | input | DW | Entered start address |
| mem_valid | output | 1 | Memory read request |
| mem_addr | output | DW | Memory read address |
| mem_ready | input | 1 | Memory read accepted, data valid |
| mem_rdata | input | DW | Memory read data |
| ld_valid | output | 1 | PC/PS load request |
| ld_pc | output | DW | PC value to load |
| ld_ps | output | DW | PS value to load |
| ld_ps_en | output | 1 | PS is loaded as well |
| ld_ready | input | 1 | Load accepted |
| chr_valid | output | 1 | Console character request |
| chr_data | output | 8 | Console character |
| chr_ready | input | 1 | Character accepted |
| bus_init | output | 1 | Bus initialize pulse |
| running | output | 1 | Program is running |
| in_console | output | 1 | Console mode |
| ucode_go | output | 1 | One-cycle hand-off to user microcode |

## Verification
The bench builds the block with a 5000 ps clock period, a 20 ns initialize time and a 40 ns wait time, so the two intervals last 4 and 8 cycles. This keeps full start sequences short, so that many of them fit in a run: back-to-back starts with and without an entered value, and halts that catch the service check. The 16-bit data width is kept, so the top octal digit carries a single bit and the 177777-style extremes are printed. The ready inputs follow mismatched periodic patterns, so every request type is seen stalled and accepted at different points.

// File: rtl/start_seq.sv
module start_seq #(
  parameter int DW      = 16,
  parameter int CLK_PS  = 5000,
  parameter int INIT_NS = 12600,
  parameter int WAIT_NS = 110000,
  parameter logic [DW-1:0] BOOT_WORD  = DW'(16'o000024),
  parameter logic [DW-1:0] BOOT_ADDR  = DW'(16'o173000),
  parameter logic [DW-1:0] TRAP_PC_AT = DW'(16'o000010),
  parameter logic [DW-1:0] TRAP_PS_AT = DW'(16'o000012)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          halt_req,
  input  logic          ucode_present,
  input  logic          instr_bnd,
  input  logic [DW-1:0] cur_pc,
  input  logic          start_cmd,
  input  logic          start_has_val,
  input  logic [DW-1:0] start_val,
  output logic          mem_valid,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          ld_valid,
  output logic [DW-1:0] ld_pc,
  output logic [DW-1:0] ld_ps,
  output logic          ld_ps_en,
  input  logic          ld_ready,
  output logic          chr_valid,
  output logic [7:0]    chr_data,
  input  logic          chr_ready,
  output logic          bus_init,
  output logic          running,
  output logic          in_console,
  output logic          ucode_go
);
  localparam int INIT_CYC = (INIT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WAIT_CYC = (WAIT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int MAXC     = (INIT_CYC > WAIT_CYC) ? INIT_CYC : WAIT_CYC;
  localparam int CW       = $clog2(MAXC + 1);
  localparam int NDIG     = (DW + 2) / 3;
  localparam int NCH      = NDIG + 3;
  localparam int IW       = $clog2(NCH + 1);

  typedef enum logic [3:0] {
    S_PWR, S_RD, S_LD, S_PRT, S_CON, S_INIT, S_WT, S_SVC, S_RUN, S_UC
  } st_t;
  typedef enum logic [1:0] {RK_BOOT, RK_TPC, RK_TPS} rk_t;

  st_t           st;
  rk_t           rdk;
  logic          hlt_q, from_start;
  logic [DW-1:0] addr_q, val_q, pc_q, ps_q;
  logic          psen_q;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;

  assign mem_valid  = (st == S_RD);
  assign mem_addr   = addr_q;
  assign ld_valid   = (st == S_LD);
  assign ld_pc      = pc_q;
  assign ld_ps      = ps_q;
  assign ld_ps_en   = psen_q;
  assign chr_valid  = (st == S_PRT);
  assign bus_init   = (st == S_INIT);
  assign running    = (st == S_RUN);
  assign in_console = (st == S_CON);
  assign ucode_go   = (st == S_UC);

  logic [3*NDIG-1:0] vx;
  logic [2:0]        dg;
  int                di, sh;
  assign vx = (3*NDIG)'(val_q);

  always_comb begin
    di = int'(idx);
    sh = (di < NDIG) ? 3 * (NDIG - 1 - di) : 0;
    dg = 3'(vx >> sh);
    if (di < NDIG)          chr_data = {5'b00110, dg};
    else if (di == NDIG)    chr_data = 8'h0D;
    else if (di == NDIG+1)  chr_data = 8'h0A;
    else                    chr_data = 8'h40;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PWR; rdk <= RK_BOOT; hlt_q <= 1'b0; from_start <= 1'b0;
      addr_q <= '0; val_q <= '0; pc_q <= '0; ps_q <= '0; psen_q <= 1'b0;
      idx <= '0; cnt <= '0;
    end else begin
      case (st)
        S_PWR: begin
          hlt_q <= halt_req;
          from_start <= 1'b0;
          case (mode_sel)
            2'd0: begin addr_q <= BOOT_WORD; rdk <= RK_BOOT; st <= S_RD; end
            2'd1: begin val_q <= cur_pc; st <= S_PRT; end
            2'd2: if (halt_req) begin
                    val_q <= BOOT_ADDR; st <= S_PRT;
                  end else begin
                    pc_q <= BOOT_ADDR; psen_q <= 1'b0; st <= S_LD;
                  end
            default: if (ucode_present) st <= S_UC;
                     else begin addr_q <= TRAP_PC_AT; rdk <= RK_TPC; st <= S_RD; end
          endcase
        end
        S_RD: if (mem_ready) begin
          case (rdk)
            RK_BOOT: if (hlt_q) begin
                       val_q <= mem_rdata; st <= S_PRT;
                     end else begin
                       pc_q <= mem_rdata; psen_q <= 1'b0; st <= S_LD;
                     end
            RK_TPC:  begin pc_q <= mem_rdata; addr_q <= TRAP_PS_AT; rdk <= RK_TPS; end
            default: begin ps_q <= mem_rdata; psen_q <= 1'b1; st <= S_LD; end
          endcase
        end
        S_LD: if (ld_ready) begin
          cnt <= '0;
          st  <= from_start ? S_INIT : S_RUN;
        end
        S_PRT: if (chr_ready) begin
          if (idx == IW'(NCH - 1)) begin idx <= '0; st <= S_CON; end
          else idx <= idx + 1'b1;
        end
        S_CON: if (start_cmd) begin
          pc_q <= start_has_val ? start_val : '0;
          ps_q <= '0; psen_q <= 1'b1; from_start <= 1'b1; st <= S_LD;
        end
        S_INIT: if (cnt == CW'(INIT_CYC - 1)) begin cnt <= '0; st <= S_WT; end
                else cnt <= cnt + 1'b1;
        S_WT:   if (cnt == CW'(WAIT_CYC - 1)) begin cnt <= '0; st <= S_SVC; end
                else cnt <= cnt + 1'b1;
        S_SVC: begin
          from_start <= 1'b0;
          if (halt_req) begin val_q <= cur_pc; st <= S_PRT; end
          else st <= S_RUN;
        end
        S_RUN: if (instr_bnd && halt_req) begin val_q <= cur_pc; st <= S_PRT; end
        default: st <= S_RUN;
      endcase
    end
  end
endmodule

// File: rtl/start_seq_chk.sv
module start_seq_chk #(
  parameter int DW       = 16,
  parameter int INIT_CYC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt_req,
  input logic          instr_bnd,
  input logic          start_cmd,
  input logic          mem_valid,
  input logic [DW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          ld_valid,
  input logic [DW-1:0] ld_pc,
  input logic [DW-1:0] ld_ps,
  input logic          ld_ps_en,
  input logic          ld_ready,
  input logic          chr_valid,
  input logic [7:0]    chr_data,
  input logic          chr_ready,
  input logic          bus_init,
  input logic          running,
  input logic          in_console,
  input logic          ucode_go
);
  int hi_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_len <= 0;
    else if (bus_init) hi_len <= hi_len + 1;
    else hi_len <= 0;

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));
  p_ld_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_ready |=> ld_valid && $stable(ld_pc) && $stable(ld_ps) && $stable(ld_ps_en));
  p_chr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && !chr_ready |=> chr_valid && $stable(chr_data));
  p_one_activity_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_valid, ld_valid, chr_valid, bus_init, running, in_console, ucode_go}));
  p_init_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_init) |-> hi_len == INIT_CYC);
  p_start_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_console && start_cmd |=> ld_valid && ld_ps_en && ld_ps == '0);
  p_ucode_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_go |=> running && !ucode_go);
  p_run_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running && !instr_bnd |=> running);
  p_run_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running && instr_bnd && halt_req |=> chr_valid);
  p_prompt_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && !$past(chr_valid) |-> chr_data[7:3] == 5'b00110);
endmodule

bind start_seq start_seq_chk #(.DW(DW), .INIT_CYC(INIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .instr_bnd(instr_bnd),
  .start_cmd(start_cmd), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .mem_ready(mem_ready), .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_ps(ld_ps),
  .ld_ps_en(ld_ps_en), .ld_ready(ld_ready), .chr_valid(chr_valid),
  .chr_data(chr_data), .chr_ready(chr_ready), .bus_init(bus_init),
  .running(running), .in_console(in_console), .ucode_go(ucode_go)
);

// File: tb/tb_start_seq.sv
`timescale 1ns/1ps
module tb_start_seq;
  localparam int CLK_PS = 5000, INIT_NS = 20, WAIT_NS = 40;
  localparam int INIT_CYC = (INIT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WAIT_CYC = (WAIT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int P_BOOT = 0, P_RD = 1, P_LD = 2, P_PRT = 3, P_CON = 4,
                 P_INIT = 5, P_WAIT = 6, P_SVC = 7, P_RUN = 8, P_UC = 9;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_sel = 0;
  logic halt_req = 0, ucode_present = 0, instr_bnd = 0;
  logic [15:0] cur_pc = 0, start_val = 0, mem_rdata;
  logic start_cmd = 0, start_has_val = 0;
  logic mem_ready = 0, ld_ready = 0, chr_ready = 0;
  logic mem_valid, ld_valid, ld_ps_en, chr_valid, bus_init, running, in_console, ucode_go;
  logic [15:0] mem_addr, ld_pc, ld_ps;
  logic [7:0] chr_data;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    case (a)
      16'o000024: return 16'o150017;
      16'o000010: return 16'o002000;
      16'o000012: return 16'o000340;
      default:    return a ^ 16'h5A5A;
    endcase
  endfunction
  assign mem_rdata = memf(mem_addr);

  start_seq #(.DW(16), .CLK_PS(CLK_PS), .INIT_NS(INIT_NS), .WAIT_NS(WAIT_NS)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .halt_req(halt_req),
    .ucode_present(ucode_present), .instr_bnd(instr_bnd), .cur_pc(cur_pc),
    .start_cmd(start_cmd), .start_has_val(start_has_val), .start_val(start_val),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_ps(ld_ps), .ld_ps_en(ld_ps_en), .ld_ready(ld_ready),
    .chr_valid(chr_valid), .chr_data(chr_data), .chr_ready(chr_ready),
    .bus_init(bus_init), .running(running), .in_console(in_console), .ucode_go(ucode_go));

  int checks = 0, errors = 0, cyc = 0, tick = 0;
  bit done = 0;
  string cur_req = "R12";

  // reference model
  int ph = P_BOOT, left = 0, kind = 0;
  bit mhalt = 0, from_st = 0, epsen = 0;
  logic [15:0] epc = 0, eps = 0, d;
  logic [15:0] rq[$];
  logic [7:0]  chq[$];

  task automatic say(input logic [15:0] v);
    for (int k = 5; k >= 0; k--) chq.push_back(8'h30 + 8'((v >> (3*k)) & 16'h7));
    chq.push_back(8'h0D); chq.push_back(8'h0A); chq.push_back(8'h40);
    ph = P_PRT;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = P_BOOT; rq.delete(); chq.delete(); from_st = 0;
    end else begin
      case (ph)
        P_BOOT: begin
          mhalt = halt_req; from_st = 0;
          case (mode_sel)
            2'd0: begin rq.delete(); rq.push_back(16'o24); kind = 0; ph = P_RD; end
            2'd1: say(cur_pc);
            2'd2: if (halt_req) say(16'o173000);
                  else begin epc = 16'o173000; epsen = 0; ph = P_LD; end
            default: if (ucode_present) ph = P_UC;
                     else begin rq.delete(); rq.push_back(16'o10); rq.push_back(16'o12); kind = 3; ph = P_RD; end
          endcase
        end
        P_RD: if (mem_ready) begin
          d = memf(rq[0]);
          if (kind == 0) begin
            void'(rq.pop_front());
            if (mhalt) say(d); else begin epc = d; epsen = 0; ph = P_LD; end
          end else if (rq.size() == 2) begin
            epc = d; void'(rq.pop_front());
          end else begin
            eps = d; epsen = 1; void'(rq.pop_front()); ph = P_LD;
          end
        end
        P_LD: if (ld_ready) begin
          if (from_st) begin ph = P_INIT; left = INIT_CYC; end else ph = P_RUN;
        end
        P_PRT: if (chr_ready) begin
          void'(chq.pop_front());
          if (chq.size() == 0) ph = P_CON;
        end
        P_CON: if (start_cmd) begin
          epc = start_has_val ? start_val : 16'h0; eps = 0; epsen = 1; from_st = 1; ph = P_LD;
        end
        P_INIT: begin left--; if (left == 0) begin ph = P_WAIT; left = WAIT_CYC; end end
        P_WAIT: begin left--; if (left == 0) ph = P_SVC; end
        P_SVC: begin from_st = 0; if (halt_req) say(cur_pc); else ph = P_RUN; end
        P_RUN: if (instr_bnd && halt_req) say(cur_pc);
        default: ph = P_RUN;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [15:0] a, input logic [15:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, a, e, cyc);
    end
  endtask

  always @(negedge clk) begin
    tick++;
    mem_ready <= (tick % 3) == 2;
    ld_ready  <= (tick % 2) == 1;
    chr_ready <= (tick % 5) != 0;
  end

  always @(negedge clk) begin
    #1;
    cyc++;
    chk({cur_req, " running"}, 16'(running), 16'(ph == P_RUN));
    chk({cur_req, " in_console"}, 16'(in_console), 16'(ph == P_CON));
    chk("R8 bus_init", 16'(bus_init), 16'(ph == P_INIT));
    chk("R5 ucode_go", 16'(ucode_go), 16'(ph == P_UC));
    chk({cur_req, " R11 mem_valid"}, 16'(mem_valid), 16'(ph == P_RD));
    if (ph == P_RD) chk({cur_req, " mem_addr"}, mem_addr, rq[0]);
    chk({cur_req, " R11 ld_valid"}, 16'(ld_valid), 16'(ph == P_LD));
    if (ph == P_LD) begin
      chk({cur_req, " ld_pc"}, ld_pc, epc);
      chk({cur_req, " ld_ps_en"}, 16'(ld_ps_en), 16'(epsen));
      if (epsen) chk({cur_req, " ld_ps"}, ld_ps, eps);
    end
    chk({cur_req, " R11 chr_valid"}, 16'(chr_valid), 16'(ph == P_PRT));
    if (ph == P_PRT) chk("R6 chr_data", 16'(chr_data), 16'(chq[0]));
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset(input logic [1:0] m, input logic h, input logic u, input string req);
    @(negedge clk);
    cur_req = "R12"; mode_sel = m; halt_req = h; ucode_present = u;
    start_cmd = 0; instr_bnd = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    cur_req = req; rst_n = 1;
  endtask

  task automatic wait_ph(input int target, input string req);
    int n = 0;
    while (ph != target && n < 2000) begin @(negedge clk); n++; end
    checks++;
    if (ph != target) begin
      errors++;
      $display("FAIL %s: actual phase %0d expected phase %0d", req, ph, target);
    end
  endtask

  task automatic pulse_start(input logic hv, input logic [15:0] v);
    @(negedge clk); start_has_val = hv; start_val = v; start_cmd = 1;
    @(negedge clk); start_cmd = 0;
  endtask

  initial begin
    // R1 then R10, R7, R8, R9
    cur_pc = 16'o000100;
    do_reset(2'd0, 1'b0, 1'b0, "R1");
    wait_ph(P_RUN, "R1");
    cur_req = "R10"; halt_req = 1; instr_bnd = 0;
    repeat (6) @(negedge clk);
    #1 chk("R10 halt without boundary", 16'(running), 16'd1);
    @(negedge clk); cur_pc = 16'o012345; instr_bnd = 1;
    @(negedge clk); instr_bnd = 0;
    wait_ph(P_CON, "R10");
    cur_req = "R7"; halt_req = 0;
    pulse_start(1'b1, 16'o001000);
    cur_req = "R8"; wait_ph(P_INIT, "R8");
    cur_req = "R9"; wait_ph(P_RUN, "R9");

    // R2 then R9 halted service, R7 ignored while running
    do_reset(2'd0, 1'b1, 1'b0, "R2");
    wait_ph(P_CON, "R2");
    cur_req = "R9"; cur_pc = 16'o177777;
    pulse_start(1'b0, 16'o055555);
    wait_ph(P_PRT, "R9");
    wait_ph(P_CON, "R9");
    halt_req = 0; cur_req = "R7";
    pulse_start(1'b1, 16'o100002);
    wait_ph(P_RUN, "R7");
    pulse_start(1'b0, 16'o0);
    repeat (3) @(negedge clk);
    #1 chk("R7 start ignored while running", 16'(running), 16'd1);

    // R3
    cur_pc = 16'o076543;
    do_reset(2'd1, 1'b0, 1'b0, "R3");
    @(negedge clk); cur_pc = 16'o000001;
    wait_ph(P_CON, "R3");
    cur_pc = 16'o100001;
    do_reset(2'd1, 1'b1, 1'b0, "R3");
    wait_ph(P_CON, "R3");

    // R4
    do_reset(2'd2, 1'b0, 1'b0, "R4");
    wait_ph(P_RUN, "R4");
    do_reset(2'd2, 1'b1, 1'b0, "R4");
    wait_ph(P_CON, "R4");
    cur_req = "R7"; halt_req = 0;
    pulse_start(1'b0, 16'o123456);
    wait_ph(P_RUN, "R7");

    // R5
    do_reset(2'd3, 1'b1, 1'b0, "R5");
    wait_ph(P_RUN, "R5");
    do_reset(2'd3, 1'b0, 1'b1, "R5");
    wait_ph(P_RUN, "R5");
    repeat (4) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule